// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block is the read path of a controller for a two-bank, single-data-rate SDRAM whose target row is already open. A user agent offers read requests (bank, start column, burst-length code, auto-precharge flag) on a valid/ready port. For every accepted request the block places one READ command on the memory command pins. It then records each expected word as a slot in command time and delays that slot through a short pipeline. The pipeline tap follows the selected CAS latency, so the capture strobe lines up with the words returning on the data bus.

A new request may be accepted while an earlier burst is still running. The new burst then takes over the very next data slot, so chained bursts arrive back to back and a long burst can be cut short. A full-page burst keeps going, with the column wrapping past the end of the page, until the user raises a stop request or a newer READ replaces it. A burst that asked for auto precharge cannot be cut short: the user port stalls until its final word has been issued. Every captured word carries its column and a marker for the last word of its burst. The CAS latency input may only change while no burst is in flight.

Top module: `sdr_read_seq`

## Requirements
- R1: The command pins show READ (sd_cs_n=0, sd_ras_n=1, sd_cas_n=0, sd_we_n=1) in the cycle after the edge that accepts a request (req_valid and req_ready high). In every other cycle they show NOP (0,1,1,1).
- R2: During a READ, sd_addr[COL_W-1:0] carries the start column, sd_addr[10] carries the auto-precharge flag, all other address bits are 0, and sd_ba carries the bank.
- R3: With CAS latency CL (cas_lat = 1, 2 or 3), word k of a request accepted at edge E is sampled from sd_dq at edge E+1+CL+k. It is presented on rd_data with rd_valid high in the cycle that follows that edge.
- R4: When req_blen[2] is 0, the burst holds 2^req_blen[1:0] words (1, 2, 4 or 8), delivered on consecutive cycles.
- R5: rd_last is high on the final delivered word of every burst, including a burst that was cut short, and on no other word.
- R6: rd_col gives the column of each word: the start column plus k, modulo 2^COL_W, so a burst wraps from the last column of the page to column 0.
- R7: When req_blen[2] is 1, the burst is full-page and continues until stop_req is high at an edge that accepts no request; the word issued at that edge is its last. stop_req has no effect at any other time.
- R8: A request accepted while an earlier burst without auto precharge still has words to issue ends that burst. The new burst's first word takes the next data slot, with no gap and no overlap.
- R9: req_ready is low from the acceptance of an auto-precharge burst until its final word has been issued. It is high in every other cycle, so a waiting request issues in the slot right after that final word.
- R10: rd_valid is high only for words scheduled by R3 to R8. After reset, req_ready is high, the pins show NOP and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat | input | 2 | CAS latency in clocks (1 to 3); change only while idle |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | 1 | Target bank |
| req_col | input | COL_W | Start column |
| req_blen | input | 3 | Burst code: bit 2 set selects full page, else 2^[1:0] words |
| req_ap | input | 1 | Auto precharge at the end of the burst |
| stop_req | input | 1 | Ends a running full-page burst |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Memory address bus |
| sd_ba | output | 1 | Bank select |
| sd_dq | input | DATA_W | Read data from the memory |
| rd_valid | output | 1 | Captured word valid |
| rd_last | output | 1 | Captured word ends its burst |
| rd_col | output | COL_W | Column of the captured word |
| rd_data | output | DATA_W | Captured word |

## Verification
Each CAS latency is swept over every fixed burst length and start columns at the page start, in the middle and at the last column. A misaligned latency tap shows up as a wrong data value, and broken column arithmetic shows up only at the page edge. Back-to-back chains, truncation after one and after several words, and a request held against an auto-precharge burst are compared slot by slot. Together they separate gap-free handover from a lost or duplicated word, and they show whether truncation moves the last marker. Full-page runs that wrap the page and end by stop, by a new READ, or by stop after an auto-precharge hold, plus stop pulses during fixed bursts and while idle, show whether stop is honoured only where it applies.

// File: rtl/sdr_rd_pkg.sv
// Shared definitions for the SDRAM read sequencer: command encodings on
// {cs_n, ras_n, cas_n, we_n} and burst-length decoding.
package sdr_rd_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [3:0] {
        CMD_READ = 4'b0101,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    // Word count of a fixed burst code (bit 2 selects full page elsewhere).
    function automatic logic [LEN_W-1:0] burst_words(input logic [2:0] code);
        return LEN_W'(1) << code[1:0];
    endfunction

endpackage

// File: rtl/sdr_rd_issue.sv
// Command-side slot tracker. Accepts requests, drives READ/NOP on
// registered command pins and emits one slot per data word in command
// time. Assumes the row is open; a new request truncates a burst unless
// the burst requested auto precharge.
module sdr_rd_issue #(
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [2:0]        req_blen,
    input  logic              req_ap,
    input  logic              stop_req,
    output logic              fire,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_ba,
    output logic              slot_valid,
    output logic              slot_last,
    output logic [COL_W-1:0]  slot_col
);
    import sdr_rd_pkg::*;

    localparam int LW = LEN_W;

    logic             busy_q, full_q, ap_q;
    logic [LW-1:0]    left_q;
    logic [COL_W-1:0] col_q;

    logic             s_v, s_l, n_busy;
    logic [COL_W-1:0] s_c;
    logic [LW-1:0]    n_left, req_words;
    logic [ADDR_W-1:0] addr_d;

    // Request acceptance: blocked only while an auto-precharge burst runs.
    assign req_ready = !(busy_q && ap_q);
    assign fire      = req_valid && req_ready;
    assign req_words = burst_words(req_blen);

    // Slot for this edge and the next tracker state.
    always_comb begin
        s_v    = 1'b0;
        s_l    = 1'b0;
        s_c    = col_q;
        n_busy = 1'b0;
        n_left = left_q;
        if (fire) begin
            s_v    = 1'b1;
            s_c    = req_col;
            s_l    = !req_blen[2] && (req_words == LW'(1));
            n_busy = !s_l;
            n_left = req_words - LW'(1);
        end else if (busy_q) begin
            s_v    = 1'b1;
            s_l    = full_q ? stop_req : (left_q == LW'(1));
            n_busy = !s_l;
            n_left = left_q - LW'(1);
        end
    end

    // Address word for a READ: column low, precharge flag on AP_BIT.
    always_comb begin
        addr_d                = '0;
        addr_d[COL_W-1:0]     = req_col;
        addr_d[AP_BIT]        = req_ap;
    end

    // Burst tracker registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            full_q <= 1'b0;
            ap_q   <= 1'b0;
            left_q <= '0;
            col_q  <= '0;
        end else begin
            busy_q <= n_busy;
            left_q <= n_left;
            if (s_v) col_q <= s_c + COL_W'(1);
            if (fire) begin
                full_q <= req_blen[2];
                ap_q   <= req_ap;
            end
        end
    end

    // Registered command pins and slot outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
            sd_addr    <= '0;
            sd_ba      <= 1'b0;
            slot_valid <= 1'b0;
            slot_last  <= 1'b0;
            slot_col   <= '0;
        end else begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= fire ? CMD_READ : CMD_NOP;
            sd_addr    <= fire ? addr_d : '0;
            sd_ba      <= fire ? req_bank : 1'b0;
            slot_valid <= s_v;
            slot_last  <= s_l;
            slot_col   <= s_c;
        end
    end

    // R1: a column strobe only ever forms the READ pattern.
    a_r1_read_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cas_n |-> (!sd_cs_n && sd_ras_n && sd_we_n));

    // R1: every accepted request is followed by a READ on the pins.
    a_r1_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !sd_cas_n);

    // R2: the precharge bit on the bus matches the accepted request.
    a_r2_ap_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (sd_addr[AP_BIT] == $past(req_ap)));

    // R9: a multi-word auto-precharge burst stalls the user port.
    a_r9_ap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_ap && !s_l) |=> !req_ready);

endmodule

// File: rtl/sdr_rd_latpipe.sv
// CAS-latency alignment and capture. Delays command-time slots through
// MAX_CL stages, taps the stage for the selected latency and captures
// sd_dq with valid, last and column tags. A cut pulse marks the slot
// being handed over as the last of its burst. Assumes cas_lat is stable
// while slots are in flight.
module sdr_rd_latpipe #(
    parameter int COL_W  = 8,
    parameter int DATA_W = 8,
    parameter int MAX_CL = 3,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [COL_W-1:0]  in_col,
    input  logic              cut,
    input  logic [DATA_W-1:0] sd_dq,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic [MAX_CL-1:0]            pv, pl;
    logic [MAX_CL-1:0][COL_W-1:0] pc;
    logic                         tap_v, tap_l;
    logic [COL_W-1:0]             tap_c;

    // Delay line: stage 0 takes the slot, later stages shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
            pl <= '0;
            pc <= '0;
        end else begin
            pv[0] <= in_valid;
            pl[0] <= in_last || cut;
            pc[0] <= in_col;
            for (int k = 1; k < MAX_CL; k++) begin
                pv[k] <= pv[k-1];
                pl[k] <= pl[k-1];
                pc[k] <= pc[k-1];
            end
        end
    end

    // Tap select: stage CL-1; latency 0 is treated as 1.
    always_comb begin
        tap_v = pv[0];
        tap_l = pl[0];
        tap_c = pc[0];
        for (int k = 1; k < MAX_CL; k++) begin
            if (int'(cas_lat) == k + 1) begin
                tap_v = pv[k];
                tap_l = pl[k];
                tap_c = pc[k];
            end
        end
    end

    // Capture register: tags the word sampled on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_col   <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= tap_v;
            rd_last  <= tap_v && tap_l;
            rd_col   <= tap_c;
            if (tap_v) rd_data <= sd_dq;
        end
    end

    // R5: a last marker never appears without a valid word.
    a_r5_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    // R3: the latency stays fixed while a slot is in the delay line.
    a_r3_cl_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (|pv) |-> $stable(cas_lat));

endmodule

// File: rtl/sdr_read_seq.sv
// SDRAM read burst sequencer top. Connects the command-side slot tracker
// to the latency-aligned capture pipeline. Assumes a two-bank SDRAM with
// the row already open and COL_W no wider than 9 address bits.
module sdr_read_seq #(
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int MAX_CL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cas_lat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [2:0]        req_blen,
    input  logic              req_ap,
    input  logic              stop_req,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_ba,
    input  logic [DATA_W-1:0] sd_dq,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data
);
    logic             fire, slot_valid, slot_last;
    logic [COL_W-1:0] slot_col;

    sdr_rd_issue #(.COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(10)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_col(req_col), .req_blen(req_blen), .req_ap(req_ap),
        .stop_req(stop_req), .fire(fire),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .slot_valid(slot_valid), .slot_last(slot_last), .slot_col(slot_col)
    );

    sdr_rd_latpipe #(.COL_W(COL_W), .DATA_W(DATA_W), .MAX_CL(MAX_CL)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
        .in_valid(slot_valid), .in_last(slot_last), .in_col(slot_col),
        .cut(fire), .sd_dq(sd_dq),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_col(rd_col), .rd_data(rd_data)
    );

    // R3: only latencies 1 to 3 are legal.
    a_r3_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat != 2'd0);

endmodule

// File: tb/sdr_read_seq_bench.sv
module sdr_read_seq_bench;
    localparam int COL_W = 4, ADDR_W = 12, DATA_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] cas_lat = 2'd1;
    logic req_valid = 1'b0, req_bank = 1'b0, req_ap = 1'b0, stop_req = 1'b0;
    logic [COL_W-1:0] req_col = '0;
    logic [2:0] req_blen = '0;
    logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic [DATA_W-1:0] sd_dq = '0;
    logic rd_valid, rd_last;
    logic [COL_W-1:0] rd_col;
    logic [DATA_W-1:0] rd_data;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdr_read_seq #(.COL_W(COL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sdr_read_seq (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_col(req_col), .req_blen(req_blen), .req_ap(req_ap), .stop_req(stop_req),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq(sd_dq),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_col(rd_col), .rd_data(rd_data)
    );

    function automatic logic [7:0] wordval(input logic b, input logic [3:0] c);
        return {(b ? 4'hA : 4'h5), c};
    endfunction

    function automatic void chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    // Memory model: streams columns from the last READ, delayed by CL.
    logic mb = 1'b0;
    logic [3:0] mc = '0;
    logic [7:0] h0 = '0, h1 = '0, h2 = '0;
    always @(posedge clk) begin
        if (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n) begin
            mb = sd_ba;
            mc = sd_addr[COL_W-1:0];
        end else mc = mc + 4'd1;
        h2 = h1; h1 = h0; h0 = wordval(mb, mc);
        sd_dq <= (cas_lat == 2'd1) ? h0 : (cas_lat == 2'd2) ? h1 : h2;
    end

    // Expected slots, computed from the requirements.
    logic ev [64];
    logic el [64];
    logic [3:0] ec [64];
    logic [7:0] ed [64];
    bit m_busy = 0, m_full = 0, m_ap = 0, m_bank = 0, prev_v = 0;
    int m_left = 0;
    logic [3:0] m_col = '0;
    bit exp_rd = 0, exp_ap = 0, exp_b = 0;
    logic [3:0] exp_c = '0;

    initial for (int i = 0; i < 64; i++) begin ev[i] = 0; el[i] = 0; ec[i] = '0; ed[i] = '0; end

    always @(posedge clk) begin
        int cl, wi, words;
        bit fire, sv, sl, sb;
        logic [3:0] sc;
        cyc++;
        cl = int'(cas_lat);
        ev[(cyc + 63) % 64] = 0;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) ev[i] = 0;
            m_busy = 0; prev_v = 0; exp_rd = 0; m_ap = 0;
        end else begin
            fire = req_valid && !(m_busy && m_ap);
            exp_rd = fire; exp_ap = req_ap; exp_b = req_bank; exp_c = req_col;
            sv = 0; sl = 0; sb = m_bank; sc = m_col;
            if (fire) begin
                words = 1 << req_blen[1:0];
                if (prev_v) el[(cyc + cl) % 64] = 1;   // R8 handover marks last
                sv = 1; sc = req_col; sb = req_bank;
                sl = !req_blen[2] && words == 1;
                m_busy = !sl; m_left = words - 1; m_full = req_blen[2];
                m_ap = req_ap; m_col = req_col + 4'd1; m_bank = req_bank;
            end else if (m_busy) begin
                sv = 1;
                sl = m_full ? stop_req : (m_left == 1);
                m_left--; m_col = m_col + 4'd1; m_busy = !sl;
            end
            if (sv) begin
                wi = (cyc + 1 + cl) % 64;
                ev[wi] = 1; el[wi] = sl; ec[wi] = sc; ed[wi] = wordval(sb, sc);
            end
            prev_v = sv;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        int i;
        logic [ADDR_W-1:0] ea;
        if (rst_n && !done) begin
            i = cyc % 64;
            chk(rd_valid == ev[i], "R3 R4 R7 R8 R10 rd_valid", int'(rd_valid), int'(ev[i]));
            if (ev[i]) begin
                chk(rd_last == el[i], "R5 rd_last", int'(rd_last), int'(el[i]));
                chk(rd_col == ec[i], "R6 rd_col", int'(rd_col), int'(ec[i]));
                chk(rd_data == ed[i], "R3 rd_data", int'(rd_data), int'(ed[i]));
            end
            chk(req_ready == !(m_busy && m_ap), "R9 req_ready", int'(req_ready), int'(!(m_busy && m_ap)));
            if (exp_rd) begin
                ea = '0; ea[3:0] = exp_c; ea[10] = exp_ap;
                chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101, "R1 READ pins",
                    int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 5);
                chk(sd_addr == ea && sd_ba == exp_b, "R2 address",
                    int'({sd_ba, sd_addr}), int'({exp_b, ea}));
            end else begin
                chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP pins",
                    int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
            end
        end
    end

    task automatic send(input bit b, input int c, input int code, input bit ap);
        @(negedge clk);
        req_valid = 1; req_bank = b; req_col = COL_W'(c); req_blen = 3'(code); req_ap = ap;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic pulse_stop_after(input int n);
        fork
            begin
                repeat (n) @(negedge clk);
                stop_req = 1;
                @(negedge clk);
                stop_req = 0;
            end
        join_none
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(rd_valid == 0, "R10 reset rd_valid", int'(rd_valid), 0);
        chk(req_ready == 1, "R10 reset req_ready", int'(req_ready), 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10 reset pins",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        rst_n = 1;
        idle(3);
        for (int cl = 1; cl <= 3; cl++) begin
            cas_lat = 2'(cl);
            idle(4);
            // R4 R6: every fixed length at page start, middle and end
            for (int code = 0; code < 4; code++) begin
                send(0, 0, code, 0); idle(10);
                send(1, 5, code, 0); idle(10);
                send(1, 15, code, 0); idle(12);
            end
            // R8: back-to-back chains
            send(0, 2, 2, 0); send(1, 9, 2, 0); send(0, 14, 0, 0); send(1, 7, 1, 1);
            idle(12);
            // R8: truncation after three words and after one word
            send(0, 3, 3, 0); idle(2); send(1, 12, 1, 0); idle(12);
            send(1, 10, 3, 0); send(0, 1, 3, 0); idle(14);
            // R9: request held against auto-precharge bursts
            send(0, 6, 2, 1); send(1, 0, 1, 0); idle(12);
            send(1, 11, 3, 1); send(0, 4, 3, 1); send(1, 2, 0, 0); idle(16);
            // R7: full page wrapping, ended by stop
            send(0, 13, 7, 0); pulse_stop_after(20); idle(30);
            // R7 R8: full page ended by a new READ
            send(1, 1, 4, 0); idle(5); send(0, 8, 0, 0); idle(12);
            // R7 R9: auto-precharge full page holds the port until stop
            pulse_stop_after(6); send(1, 2, 7, 1); send(0, 9, 1, 0); idle(14);
            // R7: stop during a fixed burst and while idle has no effect
            pulse_stop_after(2); send(0, 5, 3, 0); idle(14);
            pulse_stop_after(1); idle(6);
        end
        idle(8);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule